// File: doc/BRIEF.md
# Playback and Selftest Pattern Source

This block sits in front of a detector readout pipeline and can stand in for the live hit registers. It has three modes. In live mode the hit word and the write strobe pass through unchanged. In playback mode two stored words are fed into the pipeline, taking turns on successive pipeline writes. Each stored word is loaded bit by bit over a serial data line that is qualified by an enable. In selftest mode the block writes a checkerboard sequence into the pipeline. It then compares every word that comes back out of the derandomizer against the value it expects, and reports whether the run is still going and whether any word was wrong.

A selftest run always starts from cleared counters and a cleared failure flag, so runs can be repeated. The controller always reaches a terminal state: either the last expected word has been compared, or the read-back path has been idle for too long. A manual override can pin the playback selection to either stored word.

Top module: `dbg_pattern_src`

## Requirements
- R1: With `mode_i` at 0 (live) or 3 (spare), `pipe_data_o` equals `hit_i` and `pipe_wr_o` equals `wr_strobe_i`.
- R2: On each clock with `sh_en_i` high, the word chosen by `sh_tgt_i` (0 = word A, 1 = word B) shifts one place toward its MSB and takes `sh_dat_i` into bit 0. After PAT_W shifts, the first bit sent sits in bit PAT_W-1.
- R3: In playback (`mode_i` = 1), `pipe_wr_o` follows `wr_strobe_i` and `pipe_data_o` carries the selected stored word. The automatic selection is A on the first cycle in playback, and it flips after every cycle with `wr_strobe_i` high. Outside playback it returns to A.
- R4: While `man_en_i` is high the selection is `man_sel_i`. The automatic selection keeps advancing underneath.
- R5: `pb_busy_o` is high exactly when `mode_i` is 1. `pb_sel_o` shows the selection in effect (0 = A, 1 = B) in every mode.
- R6: In selftest (`mode_i` = 2) with no run active, `st_start_i` starts a run. The run clears the failure flag, then drives `pipe_wr_o` high for ST_LEN consecutive cycles with `st_addr_o` counting 0 to ST_LEN-1, after which `st_addr_o` holds at ST_LEN-1. In selftest mode `pipe_wr_o` is low at all other times.
- R7: In selftest mode `pipe_data_o` is the checkerboard word for `st_addr_o`. Byte k (bits 8k+7..8k) is 0xAA when k and the address are both even or both odd, and 0x55 otherwise.
- R8: Every `rb_valid_i` cycle during a run compares `rb_data_i` with the checkerboard word of a read-back index. That index starts at 0 for each run and advances by one per compare. Any mismatch sets `st_fail_o`, which stays set until the next run starts.
- R9: `st_busy_o` rises the cycle after an accepted start. It falls once, in the cycle after the ST_LEN-th compare.
- R10: After the writes are done, if ST_TMO consecutive cycles pass without `rb_valid_i`, the run ends: `st_fail_o` sets and `st_busy_o` falls.
- R11: A start while a run is active, and `rb_valid_i` while no run is active, change neither `st_busy_o` nor `st_fail_o`.
- R12: While reset is applied, and for two clocks after it is released, `st_busy_o`, `st_fail_o`, `pb_sel_o` and `st_addr_o` are 0 and both stored words are all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | 0 live, 1 playback, 2 selftest, 3 spare (acts as live) |
| hit_i | input | PAT_W | Live hit word |
| wr_strobe_i | input | 1 | Pipeline write request from memory control |
| sh_en_i | input | 1 | Serial load enable |
| sh_tgt_i | input | 1 | Serial load target, 0 = A, 1 = B |
| sh_dat_i | input | 1 | Serial load data bit |
| man_en_i | input | 1 | Manual selection enable |
| man_sel_i | input | 1 | Manual selection value |
| st_start_i | input | 1 | Selftest start request |
| rb_valid_i | input | 1 | Read-back word valid from derandomizer |
| rb_data_i | input | PAT_W | Read-back word |
| pipe_wr_o | output | 1 | Pipeline write |
| pipe_data_o | output | PAT_W | Pipeline write word |
| st_addr_o | output | $clog2(ST_LEN) | Selftest write address |
| pb_busy_o | output | 1 | Playback active |
| pb_sel_o | output | 1 | Playback selection in effect |
| st_busy_o | output | 1 | Selftest run active |
| st_fail_o | output | 1 | Selftest failure, sticky |

## Verification
The assertions assume that the memory path returns words in the order they were written and never returns more than ST_LEN words per run. They also assume that `mode_i` stays at selftest for the whole of a run. The bench's memory stand-in replays captured writes in order after a fixed latency, and it can corrupt the word at one chosen address or stay silent to force a timeout. The mode changes only while no run is active, and the single stray read-back pulse is driven only after the runs have finished.

// File: rtl/dbg_pattern_pkg.sv
package dbg_pattern_pkg;

  typedef enum logic [1:0] {
    MODE_LIVE  = 2'd0,
    MODE_PLAY  = 2'd1,
    MODE_TEST  = 2'd2,
    MODE_SPARE = 2'd3
  } src_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WRITE = 2'd1,
    ST_CHECK = 2'd2,
    ST_DONE  = 2'd3
  } st_state_e;

endpackage

// File: rtl/ckb_word.sv
// Checkerboard word generator: byte phase flips with the address parity.
module ckb_word #(
  parameter int W      = 224,
  parameter int BYTE_W = 8
) (
  input  logic         odd_i,
  output logic [W-1:0] word_o
);
  localparam int NB = W / BYTE_W;
  localparam logic [BYTE_W-1:0] PAT_HI = {(BYTE_W/2){2'b10}};
  localparam logic [BYTE_W-1:0] PAT_LO = ~PAT_HI;

  for (genvar b = 0; b < NB; b++) begin : g_byte
    localparam bit EVEN_B = (b % 2) == 0;
    assign word_o[b*BYTE_W +: BYTE_W] = (EVEN_B ^ odd_i) ? PAT_HI : PAT_LO;
  end
endmodule

// File: rtl/pb_shift_reg.sv
// Serially loaded playback word.
module pb_shift_reg #(
  parameter int W = 224
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         dat_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_q, q_d;

  always_comb begin
    q_d = q_q;
    if (en_i) q_d = {q_q[W-2:0], dat_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= '0;
    else if (en_i) q_q <= q_d;
  end

  assign q_o = q_q;

  assert_shift_in_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> (q_q[0] == $past(dat_i)));
endmodule

// File: rtl/pb_alternator.sv
// Chooses which stored word feeds the pipeline in playback.
module pb_alternator (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic play_i,
  input  logic wr_i,
  input  logic man_en_i,
  input  logic man_sel_i,
  output logic sel_o
);
  logic tog_q, tog_d;

  always_comb begin
    tog_d = tog_q;
    if (!play_i)   tog_d = 1'b0;
    else if (wr_i) tog_d = ~tog_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tog_q <= 1'b0;
    else         tog_q <= tog_d;
  end

  assign sel_o = man_en_i ? man_sel_i : tog_q;

  assert_toggle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (play_i && $past(play_i) && $past(wr_i)) |-> (tog_q != $past(tog_q)));
  assert_enter_a_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (play_i && !$past(play_i)) |-> !tog_q);
endmodule

// File: rtl/st_engine.sv
// Selftest run controller: writes the checkerboard, compares read-back.
module st_engine
  import dbg_pattern_pkg::*;
#(
  parameter int W      = 224,
  parameter int BYTE_W = 8,
  parameter int LEN    = 16,
  parameter int TMO    = 64,
  parameter int AW     = $clog2(LEN),
  parameter int TW     = $clog2(TMO + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          go_i,
  input  logic          rb_valid_i,
  input  logic [W-1:0]  rb_data_i,
  output logic          wr_o,
  output logic [AW-1:0] addr_o,
  output logic [W-1:0]  wdata_o,
  output logic          busy_o,
  output logic          fail_o
);
  localparam logic [AW-1:0] LAST = AW'(LEN - 1);
  localparam logic [TW-1:0] TLIM = TW'(TMO - 1);

  st_state_e     state_q, state_d;
  logic [AW-1:0] waddr_q, waddr_d;
  logic [AW-1:0] ridx_q,  ridx_d;
  logic [TW-1:0] tmo_q,   tmo_d;
  logic          fail_q,  fail_d;
  logic [W-1:0]  exp_word;

  ckb_word #(.W(W), .BYTE_W(BYTE_W)) i_wr_word (
    .odd_i (waddr_q[0]),
    .word_o(wdata_o)
  );

  ckb_word #(.W(W), .BYTE_W(BYTE_W)) i_exp_word (
    .odd_i (ridx_q[0]),
    .word_o(exp_word)
  );

  assign busy_o = (state_q == ST_WRITE) || (state_q == ST_CHECK);

  always_comb begin
    state_d = state_q;
    waddr_d = waddr_q;
    ridx_d  = ridx_q;
    tmo_d   = tmo_q;
    fail_d  = fail_q;
    if (!busy_o) begin
      if (go_i) begin
        state_d = ST_WRITE;
        waddr_d = '0;
        ridx_d  = '0;
        tmo_d   = '0;
        fail_d  = 1'b0;
      end
    end else begin
      if (state_q == ST_WRITE) begin
        if (waddr_q == LAST) state_d = ST_CHECK;
        else                 waddr_d = waddr_q + 1'b1;
      end
      if (rb_valid_i) begin
        tmo_d = '0;
        if (rb_data_i != exp_word) fail_d = 1'b1;
        if (ridx_q == LAST) state_d = ST_DONE;
        else                ridx_d  = ridx_q + 1'b1;
      end else if (state_q == ST_CHECK) begin
        if (tmo_q == TLIM) begin
          fail_d  = 1'b1;
          state_d = ST_DONE;
        end else begin
          tmo_d = tmo_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      waddr_q <= '0;
      ridx_q  <= '0;
      tmo_q   <= '0;
      fail_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      waddr_q <= waddr_d;
      ridx_q  <= ridx_d;
      tmo_q   <= tmo_d;
      fail_q  <= fail_d;
    end
  end

  assign wr_o   = (state_q == ST_WRITE);
  assign addr_o = waddr_q;
  assign fail_o = fail_q;

  assert_rise_clean_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> (ridx_q == '0 && waddr_q == '0 && !fail_q));
  assert_wr_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_o && $past(wr_o)) |-> (addr_o == AW'($past(addr_o) + 1'b1)));
  assert_fail_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fail_q && !(go_i && !busy_o)) |=> fail_q);
  assert_busy_end_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> ($past(rb_valid_i) || fail_q));
  assert_timeout_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CHECK && tmo_q == TLIM && !rb_valid_i) |=> (!busy_o && fail_q));
endmodule

// File: rtl/dbg_pattern_src.sv
// Debug data source in front of the readout pipeline.
module dbg_pattern_src
  import dbg_pattern_pkg::*;
#(
  parameter int PAT_W  = 224,
  parameter int BYTE_W = 8,
  parameter int ST_LEN = 16,
  parameter int ST_TMO = 64,
  localparam int AW    = $clog2(ST_LEN)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       mode_i,
  input  logic [PAT_W-1:0] hit_i,
  input  logic             wr_strobe_i,
  input  logic             sh_en_i,
  input  logic             sh_tgt_i,
  input  logic             sh_dat_i,
  input  logic             man_en_i,
  input  logic             man_sel_i,
  input  logic             st_start_i,
  input  logic             rb_valid_i,
  input  logic [PAT_W-1:0] rb_data_i,
  output logic             pipe_wr_o,
  output logic [PAT_W-1:0] pipe_data_o,
  output logic [AW-1:0]    st_addr_o,
  output logic             pb_busy_o,
  output logic             pb_sel_o,
  output logic             st_busy_o,
  output logic             st_fail_o
);
  localparam int NPAT = 2;

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rsync_q;
  logic       rst_int_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rsync_q <= 2'b00;
    else         rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  src_mode_e mode;
  logic      is_play, is_test;
  assign mode    = src_mode_e'(mode_i);
  assign is_play = (mode == MODE_PLAY);
  assign is_test = (mode == MODE_TEST);

  logic [PAT_W-1:0] pat [NPAT];

  for (genvar g = 0; g < NPAT; g++) begin : g_pat
    pb_shift_reg #(.W(PAT_W)) i_pat (
      .clk_i (clk_i),
      .rst_ni(rst_int_n),
      .en_i  (sh_en_i && (sh_tgt_i == g[0])),
      .dat_i (sh_dat_i),
      .q_o   (pat[g])
    );
  end

  logic sel;
  pb_alternator i_alt (
    .clk_i    (clk_i),
    .rst_ni   (rst_int_n),
    .play_i   (is_play),
    .wr_i     (wr_strobe_i),
    .man_en_i (man_en_i),
    .man_sel_i(man_sel_i),
    .sel_o    (sel)
  );

  logic             st_wr;
  logic [PAT_W-1:0] st_word;
  st_engine #(
    .W(PAT_W), .BYTE_W(BYTE_W), .LEN(ST_LEN), .TMO(ST_TMO), .AW(AW)
  ) i_st (
    .clk_i     (clk_i),
    .rst_ni    (rst_int_n),
    .go_i      (st_start_i && is_test),
    .rb_valid_i(rb_valid_i),
    .rb_data_i (rb_data_i),
    .wr_o      (st_wr),
    .addr_o    (st_addr_o),
    .wdata_o   (st_word),
    .busy_o    (st_busy_o),
    .fail_o    (st_fail_o)
  );

  always_comb begin
    pipe_data_o = hit_i;
    pipe_wr_o   = wr_strobe_i;
    unique case (mode)
      MODE_PLAY: pipe_data_o = pat[sel];
      MODE_TEST: begin
        pipe_data_o = st_word;
        pipe_wr_o   = st_wr;
      end
      default: ;
    endcase
  end

  assign pb_busy_o = is_play;
  assign pb_sel_o  = sel;

  assert_test_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    (is_test && !st_busy_o) |-> !pipe_wr_o);
endmodule

// File: tb/test_dbg_pattern_src.sv
module test_dbg_pattern_src;
  localparam int W   = 224;
  localparam int LEN = 16;
  localparam int TMO = 64;
  localparam int AW  = $clog2(LEN);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [W-1:0] hit = '0;
  logic wr_strobe = 0, sh_en = 0, sh_tgt = 0, sh_dat = 0;
  logic man_en = 0, man_sel = 0, st_start = 0;
  logic rb_valid = 0;
  logic [W-1:0] rb_data = '0;
  logic pipe_wr, pb_busy, pb_sel, st_busy, st_fail;
  logic [W-1:0] pipe_data;
  logic [AW-1:0] st_addr;

  always #2 clk = ~clk;  // 250 MHz

  dbg_pattern_src i_dbg_pattern_src (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .hit_i(hit),
    .wr_strobe_i(wr_strobe), .sh_en_i(sh_en), .sh_tgt_i(sh_tgt),
    .sh_dat_i(sh_dat), .man_en_i(man_en), .man_sel_i(man_sel),
    .st_start_i(st_start), .rb_valid_i(rb_valid), .rb_data_i(rb_data),
    .pipe_wr_o(pipe_wr), .pipe_data_o(pipe_data), .st_addr_o(st_addr),
    .pb_busy_o(pb_busy), .pb_sel_o(pb_sel), .st_busy_o(st_busy),
    .st_fail_o(st_fail)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  function automatic void chk(bit ok, string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endfunction

  function automatic logic [W-1:0] board(int adr);
    logic [W-1:0] w;
    for (int k = 0; k < W / 8; k++)
      w[k*8 +: 8] = (((k % 2) == 0) == ((adr % 2) == 0)) ? 8'hAA : 8'h55;
    return w;
  endfunction

  function automatic logic [W-1:0] rnd_word();
    logic [W-1:0] w;
    for (int i = 0; i < W; i += 32) w[i +: 32] = $urandom;
    return w;
  endfunction

  // Reference model state
  logic [W-1:0] mA = '0, mB = '0;
  bit mtog = 0, mfail = 0;
  int mst = 0;  // 0 idle, 1 writing, 2 awaiting read-back, 3 finished
  int mwa = 0, mri = 0, mtmo = 0, rcnt = 0, cyc = 0;

  // Memory stand-in
  logic [W-1:0] mq[$];
  int mqt[$];
  int mem_lat = 3;
  bit mem_on = 1;
  bit corrupt_en = 0;
  int corrupt_adr = 0;
  bit stray = 0;
  logic [W-1:0] stray_d = '0;

  always @(posedge clk) begin
    int nst;
    cyc++;
    if (!rst_n) begin
      rcnt = 0; mA = '0; mB = '0; mtog = 0; mfail = 0;
      mst = 0; mwa = 0; mri = 0; mtmo = 0;
    end else if (rcnt < 2) begin
      rcnt++;
    end else begin
      if (sh_en) begin
        if (sh_tgt) mB = {mB[W-2:0], sh_dat};
        else        mA = {mA[W-2:0], sh_dat};
      end
      if (mode == 2'd1) begin
        if (wr_strobe) mtog = !mtog;
      end else mtog = 0;
      if (!(mst == 1 || mst == 2)) begin
        if (st_start && mode == 2'd2) begin
          mst = 1; mwa = 0; mri = 0; mfail = 0; mtmo = 0;
        end
      end else begin
        nst = mst;
        if (mst == 1) begin
          if (mwa == LEN - 1) nst = 2;
          else mwa++;
        end
        if (rb_valid) begin
          mtmo = 0;
          if (rb_data !== board(mri)) mfail = 1;
          if (mri == LEN - 1) nst = 3;
          else mri++;
        end else if (mst == 2) begin
          if (mtmo == TMO - 1) begin mfail = 1; nst = 3; end
          else mtmo++;
        end
        mst = nst;
      end
    end
  end

  always @(negedge clk) begin
    logic [W-1:0] ed, wd;
    bit es, ew;
    string dt, wt;
    if (mq.size() > 0 && mqt[0] <= cyc) begin
      rb_valid = 1; rb_data = mq.pop_front(); void'(mqt.pop_front());
    end else begin
      rb_valid = stray; rb_data = stray_d;
    end
    #1;
    es = man_en ? man_sel : mtog;
    case (mode)
      2'd1: begin ed = es ? mB : mA; ew = wr_strobe; dt = "R3"; wt = "R3"; end
      2'd2: begin ed = board(mwa); ew = (mst == 1); dt = "R7"; wt = "R6"; end
      default: begin ed = hit; ew = wr_strobe; dt = "R1"; wt = "R1"; end
    endcase
    chk(pipe_data === ed, dt, pipe_data, ed);
    chk(pipe_wr === ew, wt, W'(pipe_wr), W'(ew));
    chk(pb_sel === es, "R4", W'(pb_sel), W'(es));
    chk(pb_busy === (mode == 2'd1), "R5", W'(pb_busy), W'(mode == 2'd1));
    chk(st_addr === AW'(mwa), "R6", W'(st_addr), W'(mwa));
    chk(st_busy === (mst == 1 || mst == 2), "R9", W'(st_busy), W'(mst == 1 || mst == 2));
    chk(st_fail === mfail, "R8", W'(st_fail), W'(mfail));
    if (mode == 2'd2 && pipe_wr === 1'b1 && mem_on) begin
      wd = pipe_data;
      if (corrupt_en && int'(st_addr) == corrupt_adr) wd[3] = ~wd[3];
      mq.push_back(wd);
      mqt.push_back(cyc + mem_lat);
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load(bit tgt, logic [W-1:0] w);
    sh_tgt = tgt; sh_en = 1;
    for (int i = W - 1; i >= 0; i--) begin
      sh_dat = w[i];
      step(1);
    end
    sh_en = 0;
  endtask

  task automatic run_test();
    st_start = 1; step(1); st_start = 0;
    step(2);
    for (int i = 0; i < 400 && st_busy; i++) step(1);
    step(1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] pa, pb;
    step(3);
    // R12: reset state
    chk(st_busy === 0 && st_fail === 0 && pb_sel === 0 && st_addr === '0, "R12",
        W'({st_busy, st_fail, pb_sel}), '0);
    rst_n = 1;
    step(1);
    chk(st_busy === 0 && st_addr === '0, "R12", W'(st_busy), '0);
    step(2);

    // R1: live and spare modes pass through
    for (int i = 0; i < 6; i++) begin
      hit = rnd_word(); wr_strobe = i[0]; step(1);
    end
    mode = 2'd3;
    for (int i = 0; i < 4; i++) begin
      hit = rnd_word(); wr_strobe = !i[0]; step(1);
    end
    mode = 2'd0; wr_strobe = 0;

    // R2: load A with a single leading one, B with random bits
    pa = '0; pa[W-1] = 1'b1;
    load(0, pa);
    pb = rnd_word();
    load(1, pb);

    // R3: playback alternation
    mode = 2'd1; step(1);
    chk(pipe_data[W-1] === 1'b1 && pipe_data[W-2:0] === '0, "R2", pipe_data, pa);
    chk(pb_sel === 1'b0, "R3", W'(pb_sel), '0);
    for (int i = 0; i < 12; i++) begin
      wr_strobe = (i % 3) != 0; step(1);
    end
    // R4: manual selection while strobes continue
    man_en = 1; man_sel = 1;
    for (int i = 0; i < 4; i++) begin wr_strobe = 1; step(1); end
    man_sel = 0;
    for (int i = 0; i < 3; i++) begin wr_strobe = i[0]; step(1); end
    man_en = 0; wr_strobe = 0;
    // R2: shifting B while it is being played
    sh_tgt = 1; sh_en = 1;
    for (int i = 0; i < 6; i++) begin sh_dat = i[1]; wr_strobe = 1; step(1); end
    sh_en = 0; wr_strobe = 0;
    mode = 2'd0; step(2);
    mode = 2'd1; step(1);
    chk(pb_sel === 1'b0, "R3", W'(pb_sel), '0);
    mode = 2'd0; step(1);

    // R6/R7/R8/R9: good selftest run, with a start pulse during the run (R11)
    mode = 2'd2; step(1);
    st_start = 1; step(1); st_start = 0;
    step(4);
    st_start = 1; step(1); st_start = 0;
    chk(st_busy === 1'b1, "R11", W'(st_busy), W'(1));
    for (int i = 0; i < 400 && st_busy; i++) step(1);
    step(1);
    chk(st_fail === 1'b0, "R8", W'(st_fail), '0);

    // R11: stray read-back with bad data while idle
    stray = 1; stray_d = '1; step(1); stray = 0; step(2);
    chk(st_fail === 1'b0 && st_busy === 1'b0, "R11", W'({st_busy, st_fail}), '0);

    // R8: corrupted word at address 5
    corrupt_en = 1; corrupt_adr = 5;
    run_test();
    chk(st_fail === 1'b1, "R8", W'(st_fail), W'(1));
    corrupt_en = 0;

    // R6: rerun clears the flag and runs the full length
    mem_lat = 1;
    run_test();
    chk(st_fail === 1'b0, "R6", W'(st_fail), '0);

    // R10: silent memory leads to a timeout
    mem_on = 0;
    run_test();
    chk(st_fail === 1'b1 && st_busy === 1'b0, "R10", W'({st_busy, st_fail}), W'(1));
    mem_on = 1; mem_lat = 5;
    run_test();
    chk(st_fail === 1'b0, "R9", W'(st_fail), '0);

    mode = 2'd0; step(3);
    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule